// File: doc/BRIEF.md
# Output Denormalizer with Channel Clamps

This block sits at the end of a pixel pipeline that carries three 12-bit components per pixel (R/Cr, G/Y, B/Cb). It accepts one pixel per clock over a valid/ready handshake. Each component is requantized by rounding to a selected output depth between 6 and 12 bits. The component is then limited to its own programmable lower and upper bound. The result leaves through a one-deep registered output stage.

Configuration arrives on plain input ports: a 3-bit depth mode and a lower and upper bound for each component. These inputs act as a pending set. The values the datapath uses are copied from them only in a cycle where the frame-start strobe is high, so a frame is never processed with mixed settings. Each output instance of the block carries its own copy of this state.

Pixels are packed with R/Cr in bits 35:24, G/Y in bits 23:12 and B/Cb in bits 11:0. A requantized N-bit result sits right-aligned in its 12-bit field, and the bits above it are zero.

Top module: `out_denorm`

## Requirements
- R1: After reset, out_valid_o is 0 and the active settings are mode 0, lower bounds 0 and upper bounds 4095, so an accepted pixel leaves unchanged.
- R2: Mode values select the output depth as follows: 1 gives 6 bits, 2 gives 8, 3 gives 9, 4 gives 10, 5 gives 11 and 6 gives 12. The result is right-aligned in each 12-bit field, with the upper bits zero.
- R3: For a depth N below 12, each component becomes floor((x + 2^(11-N)) / 2^(12-N)), which rounds half up. If this exceeds 2^N-1, the result saturates at 2^N-1. For example, at mode 1 an input of 4095 gives 63, 32 gives 1 and 31 gives 0.
- R4: Mode 0 and mode 7 pass the 12-bit component through unchanged before clamping. Mode 6 (12 bits) also leaves the value unchanged.
- R5: After requantization, a value above the upper bound is replaced by the upper bound. The result is then raised to the lower bound if it lies below it, so the lower bound wins when the lower bound exceeds the upper bound. Both bounds are compared at the output depth, against the right-aligned value.
- R6: Each component uses only its own pair of bounds (R/Cr, G/Y, B/Cb).
- R7: The configuration inputs are copied into the active settings only in a cycle with frame_start_i high. A pixel accepted in that same cycle already uses the new values. A change of the configuration inputs without the strobe has no effect on the output.
- R8: in_ready_o equals !out_valid_o || out_ready_i. An accepted pixel appears on out_pix_o with out_valid_o one cycle later. While out_valid_o is high and out_ready_i is low, out_valid_o and out_pix_o hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | Frame-start strobe; loads pending configuration |
| cfg_mode_i | input | 3 | Pending depth mode |
| cfg_lo_r_i | input | 12 | Pending R/Cr lower bound |
| cfg_hi_r_i | input | 12 | Pending R/Cr upper bound |
| cfg_lo_g_i | input | 12 | Pending G/Y lower bound |
| cfg_hi_g_i | input | 12 | Pending G/Y upper bound |
| cfg_lo_b_i | input | 12 | Pending B/Cb lower bound |
| cfg_hi_b_i | input | 12 | Pending B/Cb upper bound |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high with in_valid_i |
| in_pix_i | input | 36 | Input pixel, R/Cr 35:24, G/Y 23:12, B/Cb 11:0 |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream ready |
| out_pix_o | output | 36 | Output pixel, same packing |

## Verification
The hardest situation to reach is a stall that overlaps a change of input data. The output register must hold its pixel while a different pixel is already waiting at the input, and then take that waiting pixel in the very cycle ready returns. The bench drops out_ready_i and changes in_pix_i during the stall, then releases ready and checks each pixel in its own cycle. The second delicate case is a settings change that arrives without the strobe. The bench drives new pending values, sends a pixel with the strobe low and expects the old result, then repeats the pixel with the strobe high and expects the new one. Rounding boundaries are covered with hand-computed values at the half-step and at full-scale saturation.

// File: rtl/denorm_pkg.sv
package denorm_pkg;
  localparam int MODE_W  = 3;
  localparam int DEPTH_W = 5;

  typedef logic [MODE_W-1:0]  mode_t;
  typedef logic [DEPTH_W-1:0] depth_t;

  // 0 = no requantization
  function automatic depth_t mode_depth(mode_t m);
    case (m)
      3'd1:    mode_depth = depth_t'(6);
      3'd2:    mode_depth = depth_t'(8);
      3'd3:    mode_depth = depth_t'(9);
      3'd4:    mode_depth = depth_t'(10);
      3'd5:    mode_depth = depth_t'(11);
      3'd6:    mode_depth = depth_t'(12);
      default: mode_depth = '0;
    endcase
  endfunction
endpackage

// File: rtl/denorm_cfg_bank.sv
module denorm_cfg_bank
  import denorm_pkg::*;
#(
  parameter int CH_W   = 12,
  parameter int NUM_CH = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  mode_t                         mode_i,
  input  logic [NUM_CH-1:0][CH_W-1:0]   lo_i,
  input  logic [NUM_CH-1:0][CH_W-1:0]   hi_i,
  output mode_t                         act_mode_o,
  output logic [NUM_CH-1:0][CH_W-1:0]   act_lo_o,
  output logic [NUM_CH-1:0][CH_W-1:0]   act_hi_o,
  output mode_t                         eff_mode_o,
  output logic [NUM_CH-1:0][CH_W-1:0]   eff_lo_o,
  output logic [NUM_CH-1:0][CH_W-1:0]   eff_hi_o
);
  mode_t                       mode_q;
  logic [NUM_CH-1:0][CH_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      lo_q   <= '0;
      hi_q   <= '1;
    end else if (load_i) begin
      mode_q <= mode_i;
      lo_q   <= lo_i;
      hi_q   <= hi_i;
    end
  end

  assign act_mode_o = mode_q;
  assign act_lo_o   = lo_q;
  assign act_hi_o   = hi_q;

  // strobe cycle already sees the new set
  assign eff_mode_o = load_i ? mode_i : mode_q;
  assign eff_lo_o   = load_i ? lo_i   : lo_q;
  assign eff_hi_o   = load_i ? hi_i   : hi_q;
endmodule

// File: rtl/denorm_lane.sv
module denorm_lane
  import denorm_pkg::*;
#(
  parameter int CH_W = 12
) (
  input  logic [CH_W-1:0] pix_i,
  input  mode_t           mode_i,
  input  logic [CH_W-1:0] lo_i,
  input  logic [CH_W-1:0] hi_i,
  output logic [CH_W-1:0] pix_o
);
  localparam int     SUM_W = CH_W + 1;
  localparam depth_t FULL  = depth_t'(CH_W);

  depth_t          depth, sh;
  logic            bypass;
  logic [SUM_W-1:0] half, sum, quo, top, sat;
  logic [CH_W-1:0] rq, cl;

  always_comb begin
    depth  = mode_depth(mode_i);
    bypass = (depth == '0) || (depth >= FULL);
    sh     = bypass ? '0 : FULL - depth;
    half   = bypass ? '0 : (SUM_W'(1) << (sh - depth_t'(1)));
    sum    = {1'b0, pix_i} + half;
    quo    = sum >> sh;
    top    = (SUM_W'(1) << depth) - SUM_W'(1);
    sat    = (quo > top) ? top : quo;
    rq     = bypass ? pix_i : sat[CH_W-1:0];
    cl     = (rq > hi_i) ? hi_i : rq;
    pix_o  = (cl < lo_i) ? lo_i : cl;
  end
endmodule

// File: rtl/out_denorm.sv
module out_denorm
  import denorm_pkg::*;
#(
  parameter int CH_W   = 12,
  parameter int NUM_CH = 3,
  localparam int PIX_W = CH_W * NUM_CH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic [2:0]       cfg_mode_i,
  input  logic [CH_W-1:0]  cfg_lo_r_i,
  input  logic [CH_W-1:0]  cfg_hi_r_i,
  input  logic [CH_W-1:0]  cfg_lo_g_i,
  input  logic [CH_W-1:0]  cfg_hi_g_i,
  input  logic [CH_W-1:0]  cfg_lo_b_i,
  input  logic [CH_W-1:0]  cfg_hi_b_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [PIX_W-1:0] in_pix_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [PIX_W-1:0] out_pix_o
);
  logic [2:0][CH_W-1:0]        pend_lo, pend_hi;
  logic [NUM_CH-1:0][CH_W-1:0] cfg_lo, cfg_hi;
  logic [NUM_CH-1:0][CH_W-1:0] act_lo, act_hi, eff_lo, eff_hi;
  logic [NUM_CH-1:0][CH_W-1:0] lane_in, lane_out;
  mode_t                       act_mode, eff_mode;
  logic                        acc;

  // index 2 = R/Cr, 1 = G/Y, 0 = B/Cb
  assign pend_lo = {cfg_lo_r_i, cfg_lo_g_i, cfg_lo_b_i};
  assign pend_hi = {cfg_hi_r_i, cfg_hi_g_i, cfg_hi_b_i};

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_map
      if (c < 3) begin : g_cfg
        assign cfg_lo[c] = pend_lo[c];
        assign cfg_hi[c] = pend_hi[c];
      end else begin : g_cfg_def
        assign cfg_lo[c] = '0;
        assign cfg_hi[c] = '1;
      end
    end
  endgenerate

  denorm_cfg_bank #(.CH_W(CH_W), .NUM_CH(NUM_CH)) i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (frame_start_i),
    .mode_i     (cfg_mode_i),
    .lo_i       (cfg_lo),
    .hi_i       (cfg_hi),
    .act_mode_o (act_mode),
    .act_lo_o   (act_lo),
    .act_hi_o   (act_hi),
    .eff_mode_o (eff_mode),
    .eff_lo_o   (eff_lo),
    .eff_hi_o   (eff_hi)
  );

  assign lane_in = in_pix_i;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      denorm_lane #(.CH_W(CH_W)) i_lane (
        .pix_i  (lane_in[c]),
        .mode_i (eff_mode),
        .lo_i   (eff_lo[c]),
        .hi_i   (eff_hi[c]),
        .pix_o  (lane_out[c])
      );
    end
  endgenerate

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign acc        = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_pix_o   <= '0;
    end else if (in_ready_o) begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_pix_o <= lane_out;
    end
  end
endmodule

// File: rtl/out_denorm_chk.sv
module out_denorm_chk #(
  parameter int CH_W   = 12,
  parameter int NUM_CH = 3,
  localparam int PIX_W = CH_W * NUM_CH
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        frame_start_i,
  input logic                        in_valid_i,
  input logic                        in_ready_o,
  input logic                        out_valid_o,
  input logic                        out_ready_i,
  input logic [PIX_W-1:0]            out_pix_o,
  input logic [2:0]                  act_mode,
  input logic [NUM_CH-1:0][CH_W-1:0] act_lo,
  input logic [NUM_CH-1:0][CH_W-1:0] act_hi
);
  logic acc;
  assign acc = in_valid_i && in_ready_o;

  AST_HOLD_ON_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_pix_o)); // R8

  AST_READY_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o); // R8

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(act_mode) && $stable(act_lo) && $stable(act_hi)); // R7

  AST_TOP_IN_LIMITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !frame_start_i && (act_lo[NUM_CH-1] <= act_hi[NUM_CH-1]) |=>
      (out_pix_o[PIX_W-1 -: CH_W] <= $past(act_hi[NUM_CH-1])) &&
      (out_pix_o[PIX_W-1 -: CH_W] >= $past(act_lo[NUM_CH-1]))); // R5

  AST_LOW_IN_LIMITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !frame_start_i && (act_lo[0] <= act_hi[0]) |=>
      (out_pix_o[CH_W-1:0] <= $past(act_hi[0])) &&
      (out_pix_o[CH_W-1:0] >= $past(act_lo[0]))); // R6

  AST_SIX_BIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !frame_start_i && (act_mode == 3'd1) && (act_lo[0] < CH_W'(64)) |=>
      out_pix_o[CH_W-1:0] < CH_W'(64)); // R2
endmodule

bind out_denorm out_denorm_chk #(.CH_W(CH_W), .NUM_CH(NUM_CH)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .in_valid_i    (in_valid_i),
  .in_ready_o    (in_ready_o),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_pix_o     (out_pix_o),
  .act_mode      (act_mode),
  .act_lo        (act_lo),
  .act_hi        (act_hi)
);

// File: tb/test_out_denorm.sv
module test_out_denorm;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [2:0]  cfg_mode = '0;
  logic [11:0] lo_r = '0, hi_r = '1, lo_g = '0, hi_g = '1, lo_b = '0, hi_b = '1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [35:0] in_pix = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [35:0] out_pix;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench copy of active settings
  int m_mode = 0;
  int m_lo[3] = '{0, 0, 0};
  int m_hi[3] = '{4095, 4095, 4095};

  always #(CLK_PERIOD/2) clk = ~clk;

  out_denorm i_out_denorm (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start),
    .cfg_mode_i(cfg_mode),
    .cfg_lo_r_i(lo_r), .cfg_hi_r_i(hi_r),
    .cfg_lo_g_i(lo_g), .cfg_hi_g_i(hi_g),
    .cfg_lo_b_i(lo_b), .cfg_hi_b_i(hi_b),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_pix_i(in_pix),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_pix_o(out_pix)
  );

  function automatic int exp_ch(int x, int md, int lo, int hi);
    int n, s, y;
    case (md)
      1: n = 6;  2: n = 8;  3: n = 9;
      4: n = 10; 5: n = 11; 6: n = 12;
      default: n = 0;
    endcase
    y = x;
    if (n != 0 && n < 12) begin
      s = 12 - n;
      y = (x + (1 << (s - 1))) >> s;
      if (y > (1 << n) - 1) y = (1 << n) - 1;
    end
    if (y > hi) y = hi;
    if (y < lo) y = lo;
    return y;
  endfunction

  function automatic logic [35:0] exp_pix(logic [35:0] p);
    logic [35:0] r;
    r[35:24] = 12'(exp_ch(int'(p[35:24]), m_mode, m_lo[2], m_hi[2]));
    r[23:12] = 12'(exp_ch(int'(p[23:12]), m_mode, m_lo[1], m_hi[1]));
    r[11:0]  = 12'(exp_ch(int'(p[11:0]),  m_mode, m_lo[0], m_hi[0]));
    return r;
  endfunction

  task automatic check(string req, logic [35:0] act, logic [35:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp_v);
    end
  endtask

  task automatic set_cfg(int md, int lr, int hr, int lg, int hg, int lb, int hb);
    cfg_mode = 3'(md);
    lo_r = 12'(lr); hi_r = 12'(hr);
    lo_g = 12'(lg); hi_g = 12'(hg);
    lo_b = 12'(lb); hi_b = 12'(hb);
  endtask

  task automatic latch_model();
    m_mode = int'(cfg_mode);
    m_lo[2] = int'(lo_r); m_hi[2] = int'(hi_r);
    m_lo[1] = int'(lo_g); m_hi[1] = int'(hi_g);
    m_lo[0] = int'(lo_b); m_hi[0] = int'(hi_b);
  endtask

  // one pixel, ready high; result sampled one cycle later
  task automatic send(logic [35:0] p, bit fs, output logic [35:0] got);
    @(negedge clk);
    in_valid = 1'b1; in_pix = p; frame_start = fs;
    if (fs) latch_model();
    @(negedge clk);
    in_valid = 1'b0; frame_start = 1'b0;
    got = out_pix;
  endtask

  task automatic t_reset();
    logic [35:0] got;
    check("R1 out_valid after reset", {35'd0, out_valid}, 36'd0);
    check("R8 in_ready when empty", {35'd0, in_ready}, 36'd1);
    send(36'hFFF_800_001, 1'b0, got);
    check("R1 default passthrough", got, 36'hFFF_800_001);
  endtask

  task automatic t_bypass();
    logic [35:0] got;
    set_cfg(7, 0, 4095, 0, 4095, 0, 4095);
    send(36'h123_ABC_7FF, 1'b1, got);
    check("R4 mode 7 passthrough", got, 36'h123_ABC_7FF);
    set_cfg(0, 0, 4095, 0, 4095, 0, 4095);
    send(36'h001_FFE_800, 1'b1, got);
    check("R4 mode 0 passthrough", got, 36'h001_FFE_800);
    set_cfg(6, 0, 4095, 0, 4095, 0, 4095);
    send(36'hFFF_555_00F, 1'b1, got);
    check("R4 mode 6 full depth", got, 36'hFFF_555_00F);
  endtask

  task automatic t_depths();
    logic [35:0] got;
    // hand values: mode 1 -> 6 bits
    set_cfg(1, 0, 4095, 0, 4095, 0, 4095);
    send({12'd4095, 12'd32, 12'd31}, 1'b1, got);
    check("R3 mode1 sat/half/below", got, {12'd63, 12'd1, 12'd0});
    // mode 2 -> 8 bits: 0x7F8 -> 0x80, 0x7F7 -> 0x7F, 0xFF8 -> 0xFF sat
    set_cfg(2, 0, 4095, 0, 4095, 0, 4095);
    send({12'h7F8, 12'h7F7, 12'hFF8}, 1'b1, got);
    check("R3 mode2 rounding", got, {12'h080, 12'h07F, 12'h0FF});
    for (int md = 1; md <= 6; md++) begin
      set_cfg(md, 0, 4095, 0, 4095, 0, 4095);
      send({12'hFFF, 12'h7FF, 12'h123}, 1'b1, got);
      check($sformatf("R2 depth mode %0d", md), got, exp_pix({12'hFFF, 12'h7FF, 12'h123}));
      send({12'h001, 12'h800, 12'hAAA}, 1'b0, got);
      check($sformatf("R3 depth mode %0d", md), got, exp_pix({12'h001, 12'h800, 12'hAAA}));
    end
  endtask

  task automatic t_clamp();
    logic [35:0] got;
    set_cfg(2, 16, 200, 0, 50, 100, 255);
    send({12'h050, 12'hFFF, 12'h400}, 1'b1, got);
    // R: 0x050>>4 rounds to 5 -> 16; G: 255 -> 50; B: 64 -> 100
    check("R5 clamp low/high per channel", got, {12'd16, 12'd50, 12'd100});
    send({12'h800, 12'h100, 12'hFFF}, 1'b0, got);
    check("R6 independent bounds", got, {12'd128, 12'd16, 12'd255});
    set_cfg(0, 90, 10, 0, 4095, 0, 4095);
    send({12'h000, 12'h321, 12'hFFF}, 1'b1, got);
    check("R5 lower bound wins", got, {12'd90, 12'h321, 12'hFFF});
  endtask

  task automatic t_frame_gate();
    logic [35:0] got;
    set_cfg(0, 0, 4095, 0, 4095, 0, 4095);
    send(36'h000_000_000, 1'b1, got);
    set_cfg(1, 0, 4095, 0, 4095, 0, 4095);
    send({12'hFFF, 12'h800, 12'h040}, 1'b0, got);
    check("R7 no strobe keeps old set", got, {12'hFFF, 12'h800, 12'h040});
    send({12'hFFF, 12'h800, 12'h040}, 1'b1, got);
    check("R7 strobe cycle uses new set", got, {12'd63, 12'd32, 12'd1});
  endtask

  task automatic t_stall();
    logic [35:0] a, b;
    set_cfg(0, 0, 4095, 0, 4095, 0, 4095);
    @(negedge clk); frame_start = 1'b1; latch_model();
    @(negedge clk); frame_start = 1'b0;
    a = 36'hABC_DEF_123;
    b = 36'h456_789_0AB;
    out_ready = 1'b0;
    in_valid = 1'b1; in_pix = a;
    @(negedge clk);
    check("R8 valid after one cycle", {35'd0, out_valid}, 36'd1);
    check("R8 not ready while stalled", {35'd0, in_ready}, 36'd0);
    in_pix = b;
    repeat (2) @(negedge clk);
    check("R8 data held on stall", out_pix, a);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 waiting pixel taken", out_pix, b);
    @(negedge clk);
    check("R8 drains", {35'd0, out_valid}, 36'd0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_depths();
    t_clamp();
    t_frame_gate();
    t_stall();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule